// File: doc/BRIEF.md
# Dual-Channel PCM Transmit Serializer

This block sends two channels of 8-bit companded voice samples out on a PCM bit clock. Frames are paced by an external frame sync. On a frame start the block captures both channel samples, the mode and the format select. It then shifts the data out MSB first, one bit per bit-clock period. The MSB appears at the same clock edge that detects the frame sync.

In parallel mode each channel has its own data pin and its own output enable. Both pins drive for eight bit periods. In serial mode the channel-1 pin carries a 16-slot frame: channel 1 in slots 0 to 7, then channel 2 in slots 8 to 15. The channel-2 pin stays released in serial mode. Each output enable models the three-state driver of its pin. A data line is held low whenever its enable is low.

A power-down request releases both pins and blocks new frames. The format select is not used inside the block. It only tags the captured frame as A-law or mu-law.

Top module: `pcm_tx_serializer`

## Requirements
- R1: The output `lawTag` takes the value of `lawSelA` at each frame start and holds it until the next frame start (1 = A-law, 0 = mu-law).
- R2: A frame start occurs at a rising `bitClk` edge where `frameSync` is sampled 1, `frameSync` was sampled 0 at the previous edge, and `powerDown` is 0. From that edge on, the MSB (bit 7) of the captured samples is on the enabled data pins.
- R3: Bits go out MSB first. Each bit is held for one full `bitClk` period, and data changes only after rising edges.
- R4: In parallel mode (`serialMode` = 0 at frame start), `txData1` carries channel 1 and `txData2` carries channel 2. `txOe1` and `txOe2` are both 1 for exactly 8 periods.
- R5: In serial mode (`serialMode` = 1 at frame start), `txData1` carries channel 1 in slots 0 to 7 and channel 2 in slots 8 to 15. `txOe1` is 1 for exactly 16 periods, and `txOe2` stays 0.
- R6: Outside its transmission window each output enable is 0 and the matching data line is 0.
- R7: Samples, mode and format select are captured at frame start. Changing them during the frame does not alter that frame's output.
- R8: A frame start during an active window discards the rest of that window. The block then begins a new frame at slot 0 with newly captured samples.
- R9: While `powerDown` is sampled 1, both enables are 0 from the next edge on. Frame syncs seen in that time start no frame.
- R10: After reset (`rstN` low), both enables and both data lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | PCM bit clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Transmit frame sync; a low-to-high change starts a frame |
| serialMode | input | 1 | 1 = two channels on one pin, 0 = one pin per channel |
| powerDown | input | 1 | Power-save / power-down request; releases the outputs |
| lawSelA | input | 1 | Format tag: 1 = A-law, 0 = mu-law |
| sampleCh1 | input | 8 | Channel 1 companded sample |
| sampleCh2 | input | 8 | Channel 2 companded sample |
| txData1 | output | 1 | Channel 1 pin, or the multiplexed stream in serial mode |
| txOe1 | output | 1 | Drive enable for txData1 |
| txData2 | output | 1 | Channel 2 pin (parallel mode only) |
| txOe2 | output | 1 | Drive enable for txData2 |
| lawTag | output | 1 | Format tag of the frame now being sent |

## Verification
The window-length assertions assume that between frame starts `frameSync` goes low for at least one bit-clock period, so that every frame start can be seen. They also assume that `powerDown` changes only at safe points relative to the bit clock. The bench drives every input half a period away from the rising edge. It returns `frameSync` to low in the period after each pulse, except in the deliberate restart case. In that case the pulse is placed in the middle of a window, so the counters see a proper low-to-high change.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  typedef struct packed {
    logic load;
    logic shift1;
    logic shift2;
    logic sel2;
    logic en1;
    logic en2;
  } txStrobes_t;
endpackage

// File: rtl/pcm_tx_ctrl.sv
module pcm_tx_ctrl
  import pcm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic       bitClk,
  input  logic       rstN,
  input  logic       frameSync,
  input  logic       serialMode,
  input  logic       powerDown,
  input  logic       lawSelA,
  output txStrobes_t strobes,
  output logic       lawTag
);
  localparam int FRAME_SLOTS = 2 * SAMPLE_W;
  localparam int CNT_W = $clog2(FRAME_SLOTS);
  localparam logic [CNT_W-1:0] LAST_PAR = CNT_W'(SAMPLE_W - 1);
  localparam logic [CNT_W-1:0] LAST_SER = CNT_W'(FRAME_SLOTS - 1);
  localparam logic [CNT_W-1:0] HALF_SLOT = CNT_W'(SAMPLE_W);

  logic             fsPrev;
  logic             active;
  logic             serialLatched;
  logic [CNT_W-1:0] slotCnt;
  logic             fsRise;
  logic             inSecond;
  logic             advance;
  logic [CNT_W-1:0] lastSlot;

  assign fsRise   = frameSync & ~fsPrev;
  assign inSecond = slotCnt >= HALF_SLOT;
  assign lastSlot = serialLatched ? LAST_SER : LAST_PAR;
  assign advance  = active & ~powerDown & ~fsRise;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      fsPrev        <= 1'b0;
      active        <= 1'b0;
      serialLatched <= 1'b0;
      slotCnt       <= '0;
      lawTag        <= 1'b0;
    end else begin
      fsPrev <= frameSync;
      if (powerDown) begin
        active  <= 1'b0;
        slotCnt <= '0;
      end else if (fsRise) begin
        active        <= 1'b1;
        slotCnt       <= '0;
        serialLatched <= serialMode;
        lawTag        <= lawSelA;
      end else if (active) begin
        if (slotCnt == lastSlot) begin
          active  <= 1'b0;
          slotCnt <= '0;
        end else begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.load   = fsRise & ~powerDown;
    strobes.shift1 = advance & (~serialLatched | ~inSecond);
    strobes.shift2 = advance & (~serialLatched | inSecond);
    strobes.sel2   = serialLatched & inSecond;
    strobes.en1    = active;
    strobes.en2    = active & ~serialLatched;
  end
endmodule

// File: rtl/pcm_tx_datapath.sv
module pcm_tx_datapath
  import pcm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                bitClk,
  input  logic                rstN,
  input  txStrobes_t          strobes,
  input  logic [SAMPLE_W-1:0] sampleCh1,
  input  logic [SAMPLE_W-1:0] sampleCh2,
  output logic                txData1,
  output logic                txOe1,
  output logic                txData2,
  output logic                txOe2
);
  localparam int NUM_CH = 2;

  logic [SAMPLE_W-1:0] shiftReg [NUM_CH];
  logic [SAMPLE_W-1:0] loadVal  [NUM_CH];
  logic                shiftEn  [NUM_CH];

  assign loadVal[0] = sampleCh1;
  assign loadVal[1] = sampleCh2;
  assign shiftEn[0] = strobes.shift1;
  assign shiftEn[1] = strobes.shift2;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge bitClk or negedge rstN) begin
      if (!rstN) begin
        shiftReg[ch] <= '0;
      end else if (strobes.load) begin
        shiftReg[ch] <= loadVal[ch];
      end else if (shiftEn[ch]) begin
        shiftReg[ch] <= {shiftReg[ch][SAMPLE_W-2:0], 1'b0};
      end
    end
  end

  always_comb begin
    txOe1   = strobes.en1;
    txOe2   = strobes.en2;
    txData1 = strobes.en1 &
              (strobes.sel2 ? shiftReg[1][SAMPLE_W-1] : shiftReg[0][SAMPLE_W-1]);
    txData2 = strobes.en2 & shiftReg[1][SAMPLE_W-1];
  end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
  import pcm_tx_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                bitClk,
  input  logic                rstN,
  input  logic                frameSync,
  input  logic                serialMode,
  input  logic                powerDown,
  input  logic                lawSelA,
  input  logic [SAMPLE_W-1:0] sampleCh1,
  input  logic [SAMPLE_W-1:0] sampleCh2,
  output logic                txData1,
  output logic                txOe1,
  output logic                txData2,
  output logic                txOe2,
  output logic                lawTag
);
  txStrobes_t strobes;

  pcm_tx_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
    .bitClk(bitClk), .rstN(rstN), .frameSync(frameSync),
    .serialMode(serialMode), .powerDown(powerDown), .lawSelA(lawSelA),
    .strobes(strobes), .lawTag(lawTag)
  );

  pcm_tx_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .bitClk(bitClk), .rstN(rstN), .strobes(strobes),
    .sampleCh1(sampleCh1), .sampleCh2(sampleCh2),
    .txData1(txData1), .txOe1(txOe1), .txData2(txData2), .txOe2(txOe2)
  );
endmodule

// File: rtl/pcm_tx_checker.sv
module pcm_tx_checker #(
  parameter int SAMPLE_W = 8
) (
  input logic bitClk,
  input logic rstN,
  input logic frameSync,
  input logic powerDown,
  input logic txData1,
  input logic txOe1,
  input logic txData2,
  input logic txOe2
);
  logic       fsSeen;
  logic [5:0] winCnt1;
  logic [5:0] winCnt2;
  logic       startSeen;

  assign startSeen = frameSync & ~fsSeen & ~powerDown;

  always_ff @(posedge bitClk or negedge rstN) begin
    if (!rstN) begin
      fsSeen  <= 1'b0;
      winCnt1 <= '0;
      winCnt2 <= '0;
    end else begin
      fsSeen <= frameSync;
      if (startSeen) begin
        winCnt1 <= '0;
        winCnt2 <= '0;
      end else begin
        if (txOe1 && winCnt1 != 6'h3f) winCnt1 <= winCnt1 + 1'b1;
        if (txOe2 && winCnt2 != 6'h3f) winCnt2 <= winCnt2 + 1'b1;
      end
    end
  end

  a_r2_start_drives: assert property (@(posedge bitClk) disable iff (!rstN)
    startSeen |=> txOe1);

  a_r9_pd_release: assert property (@(posedge bitClk) disable iff (!rstN)
    powerDown |=> (!txOe1 && !txOe2));

  a_r6_idle_zero: assert property (@(posedge bitClk) disable iff (!rstN)
    ((!txOe1 -> !txData1) && (!txOe2 -> !txData2)));

  a_r5_oe1_len: assert property (@(posedge bitClk) disable iff (!rstN)
    txOe1 |-> (winCnt1 < 6'(2 * SAMPLE_W)));

  a_r4_oe2_len: assert property (@(posedge bitClk) disable iff (!rstN)
    txOe2 |-> (winCnt2 < 6'(SAMPLE_W)));

  a_r5_oe2_needs_oe1: assert property (@(posedge bitClk) disable iff (!rstN)
    txOe2 |-> txOe1);
endmodule

bind pcm_tx_serializer pcm_tx_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .bitClk(bitClk), .rstN(rstN), .frameSync(frameSync), .powerDown(powerDown),
  .txData1(txData1), .txOe1(txOe1), .txData2(txData2), .txOe2(txOe2)
);

// File: tb/sim_pcm_tx_serializer.sv
module sim_pcm_tx_serializer;
  localparam int CLK_PERIOD = 10;

  logic       bitClk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameSync = 1'b0;
  logic       serialMode = 1'b0;
  logic       powerDown = 1'b0;
  logic       lawSelA = 1'b0;
  logic [7:0] sampleCh1 = '0;
  logic [7:0] sampleCh2 = '0;
  logic       txData1, txOe1, txData2, txOe2, lawTag;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) bitClk = ~bitClk;

  pcm_tx_serializer u0 (
    .bitClk(bitClk), .rstN(rstN), .frameSync(frameSync),
    .serialMode(serialMode), .powerDown(powerDown), .lawSelA(lawSelA),
    .sampleCh1(sampleCh1), .sampleCh2(sampleCh2),
    .txData1(txData1), .txOe1(txOe1), .txData2(txData2), .txOe2(txOe2),
    .lawTag(lawTag)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkIdle(input string tag);
    check(tag, {4'b0, txOe1, txData1, txOe2, txData2}, 8'h00);
  endtask

  // Sends one frame and checks every slot; scrambles inputs mid-frame (R7).
  task automatic runFrame(input logic [7:0] a, input logic [7:0] b,
                          input logic ser, input logic law);
    @(negedge bitClk);
    sampleCh1 = a; sampleCh2 = b; serialMode = ser; lawSelA = law; frameSync = 1'b1;
    @(negedge bitClk);
    frameSync = 1'b0;
    check("R1 law tag", {7'b0, lawTag}, {7'b0, law});
    for (int s = 0; s < (ser ? 16 : 8); s++) begin
      if (s == 2) begin
        sampleCh1 = ~a; sampleCh2 = a ^ b; serialMode = ~ser; lawSelA = ~law;
      end
      if (ser) begin
        check("R5 serial oe", {6'b0, txOe1, txOe2}, 8'b10);
        check("R5 R3 R7 serial bit", {7'b0, txData1},
              {7'b0, (s < 8) ? a[7 - s] : b[15 - s]});
      end else begin
        check("R4 parallel oe", {6'b0, txOe1, txOe2}, 8'b11);
        check("R4 R3 R7 parallel bits", {6'b0, txData1, txData2},
              {6'b0, a[7 - s], b[7 - s]});
      end
      @(negedge bitClk);
    end
    checkIdle("R6 release after window");
    check("R7 law tag held", {7'b0, lawTag}, {7'b0, law});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] pa, pb;
    #(CLK_PERIOD * 3);
    checkIdle("R10 reset state");
    @(negedge bitClk);
    rstN = 1'b1;
    @(negedge bitClk);
    checkIdle("R10 after reset release");

    // R2 R4 R5: sweep of patterns in both modes
    for (int i = 0; i < 24; i++) begin
      pa = 8'(i * 37 + 5);
      pb = 8'((i * 91) ^ 8'hA6);
      runFrame(pa, pb, i[0], i[1]);
    end
    runFrame(8'hFF, 8'h00, 1'b0, 1'b1);
    runFrame(8'h00, 8'hFF, 1'b1, 1'b0);
    runFrame(8'h80, 8'h01, 1'b1, 1'b1);

    // R8: restart in the middle of a window
    @(negedge bitClk);
    sampleCh1 = 8'h3C; sampleCh2 = 8'hC3; serialMode = 1'b0; frameSync = 1'b1;
    @(negedge bitClk);
    frameSync = 1'b0;
    for (int s = 0; s < 3; s++) @(negedge bitClk);
    sampleCh1 = 8'hA5; sampleCh2 = 8'h5A; frameSync = 1'b1;
    @(negedge bitClk);
    frameSync = 1'b0;
    for (int s = 0; s < 8; s++) begin
      check("R8 restart oe", {6'b0, txOe1, txOe2}, 8'b11);
      check("R8 restart bits", {6'b0, txData1, txData2},
            {6'b0, sampleCh1[7 - s], sampleCh2[7 - s]});
      @(negedge bitClk);
    end
    checkIdle("R8 window ends 8 after restart");

    // R9: power-down cuts a frame and blocks frame syncs
    @(negedge bitClk);
    sampleCh1 = 8'hFF; sampleCh2 = 8'hFF; frameSync = 1'b1;
    @(negedge bitClk);
    frameSync = 1'b0;
    check("R9 frame running", {7'b0, txOe1}, 8'h01);
    @(negedge bitClk);
    powerDown = 1'b1;
    @(negedge bitClk);
    checkIdle("R9 released after power-down");
    frameSync = 1'b1;
    @(negedge bitClk);
    frameSync = 1'b0;
    for (int s = 0; s < 20; s++) begin
      checkIdle("R9 frame sync ignored");
      @(negedge bitClk);
    end
    powerDown = 1'b0;
    @(negedge bitClk);
    checkIdle("R9 no frame after wake");
    runFrame(8'h69, 8'h96, 1'b1, 1'b1);
    runFrame(8'h69, 8'h96, 1'b0, 1'b0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end
endmodule